// File: doc/BRIEF.md
# Multiplexed ALU Register Datapath

This block is the arithmetic core of a microcoded processor whose architectural word is 16 bits but whose adder is 32 bits wide. The wider adder serves multiply, divide and alignment steps. Each cycle, microcode fields pick a source for each of the two operands. The choices are a stored register, the system bus, a constant of all ones, or a mixed control/status bus. Further fields pick one of eight functions, give the carry-in, and name which of three result registers, if any, captures the output on the next clock edge.

The 32-bit function unit is split into eight 4-bit slices. Each slice reports a group generate and a group propagate signal to a lookahead unit, and that unit forms every slice carry-in directly. Registers never shift internally. When operand A reads register A or B, it can instead be presented one bit to the left or right, with a fill bit supplied by microcode. The result is written back to a register to complete a shift step. Decrement has no function code of its own: it is an add with the all-ones source. Carry-out and a zero-result flag are latched together with every register write so that microcode can branch on them.

Top module: `mux_alu_datapath`

## Requirements
- R1: While rst_ni is low, registers A, B and C and both latched flags are zero.
- R2: Source code 0 selects a register, 1 the system bus, 2 the all-ones constant and 3 the mixed status bus. The register select uses 0 for A, 1 for B, and 2 or 3 for C.
- R3: Function codes 0 (pass A), 1 (A AND B), 2 (A OR B), 3 (A XOR B) and 7 (NOT A) are bitwise, and for them carry_o is 0 whatever carry_i is.
- R4: Function 4 gives A + B + carry_i, and carry_o is bit 32 of that sum, including carries that cross slice boundaries.
- R5: Function 5 gives A + NOT B + carry_i, so carry_i = 1 yields A - B, with carry_o = 1 meaning no borrow.
- R6: Function 6 gives A + 1 whatever carry_i is, and carry_o is 1 only when A is all ones.
- R7: Function 4 with operand B on the all-ones source and carry_i = 0 gives A - 1, with carry_o = 0 only when A is zero.
- R8: dest_i 0 writes nothing, 1 writes A, 2 writes B and 3 writes C, at the next rising edge. Unselected registers keep their value.
- R9: When operand A reads register A or B, shift_i 1 presents it shifted left with bit 0 taken from shl_in_i. Code 2 presents it shifted right with bit 31 taken from shr_in_i. Codes 0 and 3 present it unshifted. The stored register is unchanged unless it is written.
- R10: shift_out_hi_o and shift_out_lo_o show bits 31 and 0 of the register that operand A reads when that register is A or B, and are 0 otherwise.
- R11: Register C is never shifted, whatever shift_i is, and is seen only through the operand path.
- R12: On every write (dest_i not 0), carry_flag_o captures carry_o and zero_flag_o captures whether result_o is zero. With dest_i 0, both flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_src_i | input | 2 | Operand A source select |
| a_rsel_i | input | 2 | Register read by operand A |
| b_src_i | input | 2 | Operand B source select |
| b_rsel_i | input | 2 | Register read by operand B |
| shift_i | input | 2 | Presentation shift for operand A register read |
| shl_in_i | input | 1 | Fill bit for bit 0 on left shift |
| shr_in_i | input | 1 | Fill bit for bit 31 on right shift |
| func_i | input | 3 | Function code |
| carry_i | input | 1 | Carry-in |
| dest_i | input | 2 | Destination register select |
| bus_i | input | 32 | System bus operand source |
| mix_i | input | 32 | Mixed control/status operand source |
| result_o | output | 32 | Function result |
| carry_o | output | 1 | Carry-out of the top slice |
| carry_flag_o | output | 1 | Latched carry |
| zero_flag_o | output | 1 | Latched zero-result flag |
| reg_a_o | output | 32 | Register A contents |
| reg_b_o | output | 32 | Register B contents |
| shift_out_hi_o | output | 1 | Bit 31 of the register read by operand A |
| shift_out_lo_o | output | 1 | Bit 0 of the register read by operand A |

## Verification
The bench drives carries that must cross every slice boundary: adding to 0x0FFFFFFF, and incrementing and decrementing at all-ones and at zero. A lookahead unit with a wrong term leaves a run of ones in the upper nibbles, or reports a false carry. It sends logic functions with carry_i set, and subtraction in both borrow directions, to catch a carry that leaks from arithmetic into logic, or an inverted borrow sense. Shifts are exercised in both directions with fill bits set. Register C is read with a shift requested, and code 3 is applied. A design that rotates instead of filling, or that shifts C, returns a different word. A write to one destination followed by reads of the others exposes a decoder that writes several registers or fails to hold the flags.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_ONES = 2'd2,
    SRC_MIX  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    FN_PASS = 3'd0,
    FN_AND  = 3'd1,
    FN_OR   = 3'd2,
    FN_XOR  = 3'd3,
    FN_ADD  = 3'd4,
    FN_SUB  = 3'd5,
    FN_INC  = 3'd6,
    FN_NOT  = 3'd7
  } fn_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_B    = 2'd2,
    DST_C    = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_KEEP  = 2'd3
  } sh_e;

  function automatic logic fn_is_arith(fn_e f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_INC);
  endfunction

endpackage

// File: rtl/reg_view.sv
module reg_view #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        rsel_i,
  input  logic [1:0]        shift_i,
  input  logic              shl_in_i,
  input  logic              shr_in_i,
  input  logic [DATA_W-1:0] reg_a_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic [DATA_W-1:0] reg_c_i,
  output logic [DATA_W-1:0] view_o,
  output logic              out_hi_o,
  output logic              out_lo_o
);
  import alu_dp_pkg::*;

  logic [DATA_W-1:0] picked;
  logic              shiftable;
  sh_e               sh;

  assign sh = sh_e'(shift_i);

  always_comb begin
    unique case (rsel_i)
      2'd0:    picked = reg_a_i;
      2'd1:    picked = reg_b_i;
      default: picked = reg_c_i;
    endcase
    shiftable = (rsel_i == 2'd0) || (rsel_i == 2'd1);
  end

  // neighbour-bit routing; the stored register itself never moves
  always_comb begin
    view_o = picked;
    if (shiftable) begin
      unique case (sh)
        SH_LEFT:  view_o = {picked[DATA_W-2:0], shl_in_i};
        SH_RIGHT: view_o = {shr_in_i, picked[DATA_W-1:1]};
        default:  view_o = picked;
      endcase
    end
  end

  assign out_hi_o = shiftable & picked[DATA_W-1];
  assign out_lo_o = shiftable & picked[0];

endmodule

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        src_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] mix_i,
  output logic [DATA_W-1:0] opnd_o
);
  import alu_dp_pkg::*;

  src_e src;
  assign src = src_e'(src_i);

  always_comb begin
    unique case (src)
      SRC_REG:  opnd_o = reg_i;
      SRC_BUS:  opnd_o = bus_i;
      SRC_ONES: opnd_o = '1;
      SRC_MIX:  opnd_o = mix_i;
      default:  opnd_o = reg_i;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o,
  output logic         g_o,
  output logic         p_o
);
  import alu_dp_pkg::*;

  fn_e         fn;
  logic [W-1:0] b_eff, gen, prop, sum;
  logic         cc, gg, pp;

  assign fn = fn_e'(fn_i);

  always_comb begin
    unique case (fn)
      FN_SUB:  b_eff = ~b_i;
      FN_INC:  b_eff = '0;
      default: b_eff = b_i;
    endcase
    gen  = a_i & b_eff;
    prop = a_i ^ b_eff;

    cc = cin_i;
    for (int i = 0; i < int'(W); i++) begin
      sum[i] = prop[i] ^ cc;
      cc     = gen[i] | (prop[i] & cc);
    end

    gg = 1'b0;
    pp = 1'b1;
    for (int i = 0; i < int'(W); i++) begin
      gg = gen[i] | (prop[i] & gg);
      pp = pp & prop[i];
    end
    g_o = gg;
    p_o = pp;

    unique case (fn)
      FN_PASS: y_o = a_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_NOT:  y_o = ~a_i;
      default: y_o = sum;
    endcase
  end

endmodule

// File: rtl/carry_lookahead.sv
module carry_lookahead #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         cin_i,
  output logic [N:0]   c_o
);
  logic term;

  // each carry as an explicit sum of products over lower groups
  always_comb begin
    c_o  = '0;
    term = 1'b0;
    for (int i = 0; i <= int'(N); i++) begin
      term = cin_i;
      for (int k = 0; k < i; k++) term = term & p_i[k];
      c_o[i] = term;
      for (int j = 0; j < i; j++) begin
        term = g_i[j];
        for (int k = j + 1; k < i; k++) term = term & p_i[k];
        c_o[i] = c_o[i] | term;
      end
    end
  end

endmodule

// File: rtl/mux_alu_datapath.sv
module mux_alu_datapath
  import alu_dp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SLICE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        a_src_i,
  input  logic [1:0]        a_rsel_i,
  input  logic [1:0]        b_src_i,
  input  logic [1:0]        b_rsel_i,
  input  logic [1:0]        shift_i,
  input  logic              shl_in_i,
  input  logic              shr_in_i,
  input  logic [2:0]        func_i,
  input  logic              carry_i,
  input  logic [1:0]        dest_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] mix_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_flag_o,
  output logic              zero_flag_o,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_b_o,
  output logic              shift_out_hi_o,
  output logic              shift_out_lo_o
);
  localparam int unsigned NSL = DATA_W / SLICE_W;

  logic [DATA_W-1:0] reg_a_q, reg_b_q, reg_c_q;
  logic              carry_q, zero_q;
  logic [DATA_W-1:0] a_view, b_pick, opnd_a, opnd_b, res;
  logic [NSL-1:0]    grp_g, grp_p;
  logic [NSL:0]      slc_c;
  logic              cin_eff;
  fn_e               fn;
  dst_e              dst;

  assign fn  = fn_e'(func_i);
  assign dst = dst_e'(dest_i);

  reg_view #(.DATA_W(DATA_W)) i_a_view (
    .rsel_i   (a_rsel_i),
    .shift_i  (shift_i),
    .shl_in_i (shl_in_i),
    .shr_in_i (shr_in_i),
    .reg_a_i  (reg_a_q),
    .reg_b_i  (reg_b_q),
    .reg_c_i  (reg_c_q),
    .view_o   (a_view),
    .out_hi_o (shift_out_hi_o),
    .out_lo_o (shift_out_lo_o)
  );

  always_comb begin
    unique case (b_rsel_i)
      2'd0:    b_pick = reg_a_q;
      2'd1:    b_pick = reg_b_q;
      default: b_pick = reg_c_q;
    endcase
  end

  operand_mux #(.DATA_W(DATA_W)) i_opnd_a (
    .src_i  (a_src_i),
    .reg_i  (a_view),
    .bus_i  (bus_i),
    .mix_i  (mix_i),
    .opnd_o (opnd_a)
  );

  operand_mux #(.DATA_W(DATA_W)) i_opnd_b (
    .src_i  (b_src_i),
    .reg_i  (b_pick),
    .bus_i  (bus_i),
    .mix_i  (mix_i),
    .opnd_o (opnd_b)
  );

  assign cin_eff = (fn == FN_INC) ? 1'b1 : carry_i;

  carry_lookahead #(.N(NSL)) i_cla (
    .g_i   (grp_g),
    .p_i   (grp_p),
    .cin_i (cin_eff),
    .c_o   (slc_c)
  );

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) i_slice (
      .a_i   (opnd_a[s*SLICE_W +: SLICE_W]),
      .b_i   (opnd_b[s*SLICE_W +: SLICE_W]),
      .fn_i  (func_i),
      .cin_i (slc_c[s]),
      .y_o   (res[s*SLICE_W +: SLICE_W]),
      .g_o   (grp_g[s]),
      .p_o   (grp_p[s])
    );
  end

  assign result_o = res;
  assign carry_o  = fn_is_arith(fn) ? slc_c[NSL] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
      reg_b_q <= '0;
      reg_c_q <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      unique case (dst)
        DST_A:   reg_a_q <= res;
        DST_B:   reg_b_q <= res;
        DST_C:   reg_c_q <= res;
        default: ;
      endcase
      if (dst != DST_NONE) begin
        carry_q <= carry_o;
        zero_q  <= (res == '0);
      end
    end
  end

  assign reg_a_o      = reg_a_q;
  assign reg_b_o      = reg_b_q;
  assign carry_flag_o = carry_q;
  assign zero_flag_o  = zero_q;

endmodule

// File: rtl/alu_dp_checker.sv
module alu_dp_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SLICE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        a_src_i,
  input logic [1:0]        a_rsel_i,
  input logic [1:0]        b_src_i,
  input logic [1:0]        b_rsel_i,
  input logic [1:0]        shift_i,
  input logic              shl_in_i,
  input logic              shr_in_i,
  input logic [2:0]        func_i,
  input logic              carry_i,
  input logic [1:0]        dest_i,
  input logic [DATA_W-1:0] bus_i,
  input logic [DATA_W-1:0] mix_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              carry_flag_o,
  input logic              zero_flag_o,
  input logic [DATA_W-1:0] reg_a_o,
  input logic [DATA_W-1:0] reg_b_o,
  input logic              shift_out_hi_o,
  input logic              shift_out_lo_o
);

  AST_DEST_A_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i == 2'd1 |=> reg_a_o == $past(result_o)); // R8
  AST_DEST_B_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i == 2'd2 |=> reg_b_o == $past(result_o)); // R8
  AST_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i != 2'd1 |=> $stable(reg_a_o)); // R8
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i != 2'd2 |=> $stable(reg_b_o)); // R8
  AST_CARRY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i != 2'd0 |=> carry_flag_o == $past(carry_o)); // R12
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i != 2'd0 |=> zero_flag_o == ($past(result_o) == '0)); // R12
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i == 2'd0 |=> $stable(carry_flag_o) && $stable(zero_flag_o)); // R12
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i <= 3'd3 || func_i == 3'd7) |-> !carry_o); // R3
  AST_ONES_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_src_i == 2'd1 && b_src_i == 2'd2 && func_i == 3'd4 && !carry_i)
    |-> result_o == bus_i - 1'b1); // R7
  AST_MIX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_src_i == 2'd3 && func_i == 3'd0) |-> result_o == mix_i); // R2
  AST_B_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_src_i == 2'd2 && b_src_i == 2'd0 && b_rsel_i == 2'd1 && func_i == 3'd1)
    |-> result_o == reg_b_o); // R2
  AST_SHIFT_LEFT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_src_i == 2'd0 && a_rsel_i == 2'd0 && shift_i == 2'd1 && func_i == 3'd0)
    |-> result_o == {reg_a_o[DATA_W-2:0], shl_in_i}); // R9
  AST_SHIFT_RIGHT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_src_i == 2'd0 && a_rsel_i == 2'd1 && shift_i == 2'd2 && func_i == 3'd0)
    |-> result_o == {shr_in_i, reg_b_o[DATA_W-1:1]}); // R9
  AST_SHIFT_OUT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rsel_i == 2'd0 |-> shift_out_hi_o == reg_a_o[DATA_W-1] &&
                         shift_out_lo_o == reg_a_o[0]); // R10

endmodule

bind mux_alu_datapath alu_dp_checker #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_chk (.*);

// File: tb/test_mux_alu_datapath.sv
`timescale 1ns/1ps
module test_mux_alu_datapath;

  localparam logic [1:0] S_REG = 2'd0, S_BUS = 2'd1, S_ONES = 2'd2, S_MIX = 2'd3;
  localparam logic [2:0] F_PASS = 3'd0, F_AND = 3'd1, F_OR = 3'd2, F_XOR = 3'd3,
                         F_ADD = 3'd4, F_SUB = 3'd5, F_INC = 3'd6, F_NOT = 3'd7;
  localparam logic [1:0] D_NONE = 2'd0, D_A = 2'd1, D_B = 2'd2, D_C = 2'd3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] a_src_i = '0, a_rsel_i = '0, b_src_i = '0, b_rsel_i = '0, shift_i = '0, dest_i = '0;
  logic shl_in_i = 1'b0, shr_in_i = 1'b0, carry_i = 1'b0;
  logic [2:0] func_i = '0;
  logic [31:0] bus_i = '0, mix_i = '0;
  logic [31:0] result_o, reg_a_o, reg_b_o;
  logic carry_o, carry_flag_o, zero_flag_o, shift_out_hi_o, shift_out_lo_o;

  mux_alu_datapath i_mux_alu_datapath (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    bit          kind;
    logic [31:0] res;
    logic        cy, hi, lo;
    logic [31:0] ra, rb;
    logic        cf, zf;
    string       req;
  } item_t;

  item_t q[$];
  event  ev;
  int    nchk = 0, nfail = 0;
  logic [31:0] ma = '0, mb = '0, mc = '0;
  logic        mcf = 1'b0, mzf = 1'b0;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.kind == 1'b0) begin
        cmp(it.req, "result", result_o, it.res);
        cmp(it.req, "carry", {31'd0, carry_o}, {31'd0, it.cy});
        cmp(it.req, "shout", {30'd0, shift_out_hi_o, shift_out_lo_o}, {30'd0, it.hi, it.lo});
      end else begin
        cmp(it.req, "reg_a", reg_a_o, it.ra);
        cmp(it.req, "reg_b", reg_b_o, it.rb);
        cmp(it.req, "flags", {30'd0, carry_flag_o, zero_flag_o}, {30'd0, it.cf, it.zf});
      end
    end
  end

  function automatic logic [31:0] pick(logic [1:0] rs);
    return (rs == 2'd0) ? ma : (rs == 2'd1) ? mb : mc;
  endfunction

  task automatic step(logic [1:0] as, logic [1:0] ar, logic [1:0] bs, logic [1:0] br,
                      logic [2:0] fn, logic ci, logic [1:0] ds, logic [1:0] sh,
                      logic sl, logic sr, logic [31:0] bv, logic [31:0] mv, string req);
    item_t it;
    logic [31:0] rv, oa, ob, rb_v;
    logic [32:0] r;
    @(negedge clk_i);
    a_src_i = as; a_rsel_i = ar; b_src_i = bs; b_rsel_i = br; func_i = fn;
    carry_i = ci; dest_i = ds; shift_i = sh; shl_in_i = sl; shr_in_i = sr;
    bus_i = bv; mix_i = mv;
    rv = pick(ar);
    if (ar < 2'd2 && sh == 2'd1) rv = {rv[30:0], sl};
    else if (ar < 2'd2 && sh == 2'd2) rv = {sr, rv[31:1]};
    oa = (as == S_REG) ? rv : (as == S_BUS) ? bv : (as == S_ONES) ? 32'hFFFF_FFFF : mv;
    rb_v = pick(br);
    ob = (bs == S_REG) ? rb_v : (bs == S_BUS) ? bv : (bs == S_ONES) ? 32'hFFFF_FFFF : mv;
    case (fn)
      F_PASS:  r = {1'b0, oa};
      F_AND:   r = {1'b0, oa & ob};
      F_OR:    r = {1'b0, oa | ob};
      F_XOR:   r = {1'b0, oa ^ ob};
      F_ADD:   r = {1'b0, oa} + {1'b0, ob} + {32'd0, ci};
      F_SUB:   r = {1'b0, oa} + {1'b0, ~ob} + {32'd0, ci};
      F_INC:   r = {1'b0, oa} + 33'd1;
      default: r = {1'b0, ~oa};
    endcase
    it.kind = 1'b0; it.res = r[31:0]; it.cy = r[32];
    it.hi = (ar < 2'd2) ? pick(ar)[31] : 1'b0;
    it.lo = (ar < 2'd2) ? pick(ar)[0] : 1'b0;
    it.ra = '0; it.rb = '0; it.cf = 1'b0; it.zf = 1'b0; it.req = req;
    q.push_back(it);
    ->ev;
    case (ds)
      D_A: ma = r[31:0];
      D_B: mb = r[31:0];
      D_C: mc = r[31:0];
      default: ;
    endcase
    if (ds != D_NONE) begin
      mcf = r[32];
      mzf = (r[31:0] == 32'd0);
    end
  endtask

  task automatic chk_regs(string req);
    item_t it;
    @(negedge clk_i);
    dest_i = D_NONE;
    it.kind = 1'b1; it.res = '0; it.cy = 1'b0; it.hi = 1'b0; it.lo = 1'b0;
    it.ra = ma; it.rb = mb; it.cf = mcf; it.zf = mzf; it.req = req;
    q.push_back(it);
    ->ev;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    chk_regs("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 sources, R8 destinations
    step(S_BUS, 0, S_ONES, 0, F_PASS, 0, D_A, 0, 0, 0, 32'h0000_FFFF, 0, "R2");
    step(S_MIX, 0, S_ONES, 0, F_PASS, 0, D_B, 0, 0, 0, 0, 32'h1234_5678, "R2");
    chk_regs("R8");
    step(S_ONES, 0, S_BUS, 0, F_PASS, 0, D_NONE, 0, 0, 0, 32'hAAAA_5555, 0, "R2");
    // R4 add of two registers into C
    step(S_REG, 0, S_REG, 1, F_ADD, 0, D_C, 0, 0, 0, 0, 0, "R4");
    chk_regs("R8");
    // R11 C read with shift requested stays unshifted, no shift-out
    step(S_REG, 2, S_ONES, 0, F_PASS, 0, D_NONE, 1, 1, 1, 0, 0, "R11");
    step(S_REG, 3, S_ONES, 0, F_PASS, 0, D_NONE, 2, 1, 1, 0, 0, "R11");
    // R4 carry across all slices
    step(S_BUS, 0, S_MIX, 0, F_ADD, 0, D_NONE, 0, 0, 0, 32'h0FFF_FFFF, 32'd1, "R4");
    step(S_BUS, 0, S_MIX, 0, F_ADD, 1, D_NONE, 0, 0, 0, 32'hFFFF_FFFF, 32'd0, "R4");
    step(S_BUS, 0, S_MIX, 0, F_ADD, 1, D_NONE, 0, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    // R6 increment ignores carry_i; R12 flags on wrap
    step(S_BUS, 0, S_MIX, 0, F_INC, 0, D_A, 0, 0, 0, 32'hFFFF_FFFF, 32'h5, "R6");
    chk_regs("R12");
    step(S_BUS, 0, S_MIX, 0, F_INC, 1, D_NONE, 0, 0, 0, 32'h0000_00FF, 32'h5, "R6");
    // R7 decrement via all-ones source
    step(S_REG, 1, S_ONES, 0, F_ADD, 0, D_NONE, 0, 0, 0, 0, 0, "R7");
    step(S_REG, 0, S_ONES, 0, F_ADD, 0, D_C, 0, 0, 0, 0, 0, "R7");
    chk_regs("R12");
    step(S_BUS, 0, S_ONES, 0, F_ADD, 0, D_NONE, 0, 0, 0, 32'h0001_0000, 0, "R7");
    // R5 subtract both borrow directions
    step(S_BUS, 0, S_MIX, 0, F_SUB, 1, D_NONE, 0, 0, 0, 32'd5, 32'd7, "R5");
    step(S_BUS, 0, S_MIX, 0, F_SUB, 1, D_B, 0, 0, 0, 32'd7, 32'd5, "R5");
    chk_regs("R12");
    // R3 logic with carry_i set
    step(S_BUS, 0, S_MIX, 0, F_AND, 1, D_NONE, 0, 0, 0, 32'hF0F0_1234, 32'hFF00_FFFF, "R3");
    step(S_BUS, 0, S_MIX, 0, F_OR,  1, D_NONE, 0, 0, 0, 32'hF0F0_1234, 32'h0F00_0001, "R3");
    step(S_BUS, 0, S_MIX, 0, F_XOR, 1, D_NONE, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    step(S_BUS, 0, S_MIX, 0, F_NOT, 1, D_A, 0, 0, 0, 32'h8000_0001, 0, "R3");
    chk_regs("R12");
    // R9/R10 presentation shifts on A and B
    step(S_REG, 0, S_ONES, 0, F_PASS, 0, D_NONE, 1, 1, 0, 0, 0, "R9");
    step(S_REG, 0, S_ONES, 0, F_PASS, 0, D_NONE, 2, 0, 1, 0, 0, "R9");
    step(S_REG, 0, S_ONES, 0, F_PASS, 0, D_NONE, 3, 1, 1, 0, 0, "R9");
    step(S_REG, 1, S_ONES, 0, F_PASS, 0, D_B, 1, 1, 1, 0, 0, "R10");
    step(S_REG, 1, S_ONES, 0, F_PASS, 0, D_B, 2, 0, 1, 0, 0, "R10");
    chk_regs("R9");
    // R8 no-write keeps everything; R12 flags hold
    step(S_BUS, 0, S_MIX, 0, F_ADD, 1, D_NONE, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    chk_regs("R12");
    step(S_REG, 2, S_ONES, 0, F_PASS, 0, D_NONE, 0, 0, 0, 0, 0, "R11");
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #800000;
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule